// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose procedure calls switch register windows instead of copying arguments. Software always sees 32 registers, numbered 0 to 31 and split into four groups of eight: globals (0-7), outputs (8-15), locals (16-23) and inputs (24-31). The storage behind them is larger. It holds 8 shared globals plus 16 registers per window, where the window count `NWIN` is a parameter with a default of 8. A current-window pointer turns every register number into a physical index. The outputs of one window occupy the same storage as the inputs of the window a call moves into, so arguments and return values cross the call boundary without any copy.

A call issues `save_req`, which steps the pointer down by one, modulo `NWIN`. A return issues `restore_req`, which steps it up by one. Software supplies a mask `win_mask` marking windows that must not be entered; a step into a marked window is refused. A small state machine tracks this with three states:
- `WIN_STEADY`: no fault is reported.
- `WIN_OVF`: the previous cycle's save was refused.
- `WIN_UNF`: the previous cycle's restore was refused.

The transitions are:
- save refused: any state goes to `WIN_OVF`.
- restore refused: any state goes to `WIN_UNF`.
- accepted step, or no strobe: any state goes to `WIN_STEADY`.

There are two combinational read ports and one write port that writes on the rising clock edge. All three ports are addressed by architectural register numbers. Register 0 is constant zero.

Top module: `wreg_file`

## Requirements
- R1: After reset, `cur_win` is 0, and `ovf` and `unf` are low.
- R2: Each read port returns, in the same cycle and combinationally, the value of the register named by its 5-bit index under the current window; both ports return the same value for the same index.
- R3: With `wr_en` high, `wr_data` is stored on the rising edge into the register named by `wr_idx` under the current window, and reads back from the following cycle.
- R4: Register 0 always reads 0, and a write to it has no effect.
- R5: Globals 1-7 are one set of storage shared by every window.
- R6: Locals 16-23 are private to each window; writing them in one window leaves the locals of other windows unchanged.
- R7: Output register 8+k of window w is the same storage as input register 24+k of window (w-1) mod `NWIN`, including the wrap from window 0 to window `NWIN`-1.
- R8: An accepted `save_req` sets `cur_win` to (`cur_win`-1) mod `NWIN`; an accepted `restore_req` sets it to (`cur_win`+1) mod `NWIN`.
- R9: If `win_mask` bit i is 1 (bit i stands for window i) and a save targets window i, `cur_win` is unchanged and `ovf` is high for the one cycle after the request.
- R10: If a restore targets a window whose `win_mask` bit is 1, `cur_win` is unchanged and `unf` is high for the one cycle after the request.
- R11: If `save_req` and `restore_req` are high together, the save is acted on and the restore is ignored.
- R12: A read of a register in the same cycle it is written returns the value it held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the window pointer and fault state |
| rd_a_idx | input | 5 | Architectural index for read port A |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Architectural index for read port B |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index for the write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Step to the callee window |
| restore_req | input | 1 | Step back to the caller window |
| win_mask | input | NWIN | Bit i set marks window i as not enterable |
| cur_win | output | WPW | Current window pointer |
| ovf | output | 1 | A save was refused in the previous cycle |
| unf | output | 1 | A restore was refused in the previous cycle |

## Verification
The assertions take for granted that the indices, strobes and mask carry known values at every clock edge, and that `win_mask` is only consulted in a cycle with a strobe. The write check relies on a write and a window step in the same cycle being disambiguated by comparing the pointer before and after. The bench changes every input at the falling edge and holds it for a full cycle. It releases reset with the mask cleared and only ever marks a window that a following strobe is meant to hit.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
    localparam int ARCH_W  = 5;
    localparam int GROUP_N = 8;

    typedef enum logic [1:0] {
        WIN_STEADY = 2'd0,
        WIN_OVF    = 2'd1,
        WIN_UNF    = 2'd2
    } win_st_e;
endpackage

// File: rtl/wreg_win_ctrl.sv
module wreg_win_ctrl
    import wreg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int WPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] win_mask,
    output logic [WPW-1:0]  cwp,
    output logic            ovf,
    output logic            unf
);
    win_st_e        state, state_n;
    logic [WPW-1:0] cwp_n, nxt_dn, nxt_up;

    always_comb begin
        nxt_dn = (cwp == '0) ? WPW'(NWIN - 1) : cwp - 1'b1;
        nxt_up = (cwp == WPW'(NWIN - 1)) ? '0 : cwp + 1'b1;
        state_n = WIN_STEADY;
        cwp_n   = cwp;
        unique case ({save_req, restore_req})
            2'b10, 2'b11: begin
                if (win_mask[nxt_dn]) state_n = WIN_OVF;
                else                  cwp_n   = nxt_dn;
            end
            2'b01: begin
                if (win_mask[nxt_up]) state_n = WIN_UNF;
                else                  cwp_n   = nxt_up;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WIN_STEADY;
            cwp   <= '0;
        end else begin
            state <= state_n;
            cwp   <= cwp_n;
        end
    end

    always_comb begin
        ovf = 1'b0;
        unf = 1'b0;
        unique case (state)
            WIN_STEADY: ;
            WIN_OVF:    ovf = 1'b1;
            WIN_UNF:    unf = 1'b1;
            default:    ;
        endcase
    end

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WIN_OVF) |-> (cwp == $past(cwp)));

    // R10
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WIN_UNF) |-> (cwp == $past(cwp)));

    // R11
    save_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> (state != WIN_UNF));

    // R8
    step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp != $past(cwp)) |-> ($past(save_req) || $past(restore_req)));
endmodule

// File: rtl/wreg_map.sv
module wreg_map
    import wreg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int WPW  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int PHYS = GROUP_N + 2 * GROUP_N * NWIN,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic [WPW-1:0]    win,
    input  logic [ARCH_W-1:0] arch,
    output logic [PW-1:0]     phys
);
    logic [WPW-1:0] win_up;
    logic [PW-1:0]  base_cur, base_up, offs;

    always_comb begin
        win_up   = (win == WPW'(NWIN - 1)) ? '0 : win + 1'b1;
        base_cur = PW'(GROUP_N) + PW'(win) * PW'(2 * GROUP_N);
        base_up  = PW'(GROUP_N) + PW'(win_up) * PW'(2 * GROUP_N);
        offs     = PW'(arch[2:0]);
        unique case (arch[4:3])
            2'b00:   phys = offs;
            2'b01:   phys = base_cur + offs;
            2'b10:   phys = base_cur + PW'(GROUP_N) + offs;
            2'b11:   phys = base_up + offs;
            default: phys = offs;
        endcase
    end
endmodule

// File: rtl/wreg_array.sv
module wreg_array #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 136,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [PW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [PW-1:0]   raddr_a,
    input  logic [PW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/wreg_file.sv
module wreg_file
    import wreg_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NWIN = 8,
    localparam int WPW  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int PHYS = GROUP_N + 2 * GROUP_N * NWIN,
    localparam int PW   = $clog2(PHYS),
    localparam int NPRT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] win_mask,
    output logic [WPW-1:0]  cur_win,
    output logic            ovf,
    output logic            unf
);
    logic [NPRT-1:0][ARCH_W-1:0] arch_sel;
    logic [PW-1:0]               phys_sel [NPRT];
    logic [XLEN-1:0]             raw_a, raw_b;
    logic                        wr_live;

    wreg_win_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .win_mask    (win_mask),
        .cwp         (cur_win),
        .ovf         (ovf),
        .unf         (unf)
    );

    assign arch_sel = {wr_idx, rd_b_idx, rd_a_idx};

    for (genvar p = 0; p < NPRT; p++) begin : g_map
        wreg_map #(.NWIN(NWIN)) u_map (
            .win  (cur_win),
            .arch (arch_sel[p]),
            .phys (phys_sel[p])
        );
    end

    assign wr_live = wr_en && (wr_idx != '0);

    wreg_array #(.XLEN(XLEN), .DEPTH(PHYS)) u_array (
        .clk     (clk),
        .we      (wr_live),
        .waddr   (phys_sel[2]),
        .wdata   (wr_data),
        .raddr_a (phys_sel[0]),
        .raddr_b (phys_sel[1]),
        .rdata_a (raw_a),
        .rdata_b (raw_b)
    );

    assign rd_a_data = (rd_a_idx == '0) ? '0 : raw_a;
    assign rd_b_data = (rd_b_idx == '0) ? '0 : raw_b;

    // R2
    port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

    // R3
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_idx) != '0) && (cur_win == $past(cur_win))
         && (rd_a_idx == $past(wr_idx)) && !(wr_en && (wr_idx == rd_a_idx)))
        |-> (rd_a_data == $past(wr_data)));
endmodule

// File: tb/tb_wreg_file.sv
module tb_wreg_file;
    localparam int XLEN = 32;
    localparam int NWIN = 8;
    localparam int WPW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic            wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [NWIN-1:0] win_mask = '0;
    logic [WPW-1:0]  cur_win;
    logic            ovf, unf;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wreg_file #(.XLEN(XLEN), .NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req), .win_mask(win_mask),
        .cur_win(cur_win), .ovf(ovf), .unf(unf)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [4:0] idx, input logic [31:0] val);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input logic [4:0] idx, input logic [31:0] exp, input string req);
        rd_a_idx = idx; rd_b_idx = idx;
        #1;
        check(rd_a_data === exp, req, rd_a_data, exp);
        check(rd_b_data === exp, req, rd_b_data, exp);
    endtask

    task automatic strobe(input bit s, input bit r);
        save_req = s; restore_req = r;
        @(posedge clk); @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0;
    endtask

    task automatic t_reset();
        check(cur_win == 0, "R1", 32'(cur_win), 0);
        check(ovf == 0 && unf == 0, "R1", {30'd0, ovf, unf}, 0);
        read_chk(5'd0, 32'd0, "R4");
    endtask

    task automatic t_globals();
        for (int i = 1; i < 8; i++) write_reg(5'(i), 32'h100 + i);
        for (int i = 1; i < 8; i++) read_chk(5'(i), 32'h100 + i, "R2");
    endtask

    task automatic t_zero();
        write_reg(5'd0, 32'hDEAD_BEEF);
        read_chk(5'd0, 32'd0, "R4");
    endtask

    task automatic t_windows();
        write_reg(5'd8, 32'hA0A0_0001);
        write_reg(5'd16, 32'h1111_0000);
        strobe(1'b1, 1'b0);
        check(cur_win == 7, "R8", 32'(cur_win), 7);
        read_chk(5'd24, 32'hA0A0_0001, "R7");
        write_reg(5'd16, 32'h7777_0000);
        write_reg(5'd31, 32'hB0B0_0002);
        read_chk(5'd1, 32'h101, "R5");
        read_chk(5'd16, 32'h7777_0000, "R6");
        strobe(1'b0, 1'b1);
        check(cur_win == 0, "R8", 32'(cur_win), 0);
        read_chk(5'd15, 32'hB0B0_0002, "R7");
        read_chk(5'd16, 32'h1111_0000, "R6");
        read_chk(5'd7, 32'h107, "R5");
    endtask

    task automatic t_cycle();
        for (int i = 1; i <= 8; i++) begin
            strobe(1'b0, 1'b1);
            check(cur_win == WPW'(i % 8), "R8", 32'(cur_win), 32'(i % 8));
        end
    endtask

    task automatic t_ovf();
        win_mask = 8'h80;
        strobe(1'b1, 1'b0);
        check(cur_win == 0, "R9", 32'(cur_win), 0);
        check(ovf == 1 && unf == 0, "R9", {30'd0, ovf, unf}, 32'd2);
        @(posedge clk); @(negedge clk);
        check(ovf == 0, "R9", 32'(ovf), 0);
        win_mask = '0;
    endtask

    task automatic t_unf();
        win_mask = 8'h02;
        strobe(1'b0, 1'b1);
        check(cur_win == 0, "R10", 32'(cur_win), 0);
        check(unf == 1 && ovf == 0, "R10", {30'd0, ovf, unf}, 32'd1);
        @(posedge clk); @(negedge clk);
        check(unf == 0, "R10", 32'(unf), 0);
        win_mask = '0;
    endtask

    task automatic t_both();
        strobe(1'b1, 1'b1);
        check(cur_win == 7, "R11", 32'(cur_win), 7);
        check(unf == 0 && ovf == 0, "R11", {30'd0, ovf, unf}, 0);
        strobe(1'b0, 1'b1);
        check(cur_win == 0, "R8", 32'(cur_win), 0);
    endtask

    task automatic t_rdw();
        wr_en = 1'b1; wr_idx = 5'd2; wr_data = 32'h0000_0077;
        rd_a_idx = 5'd2; rd_b_idx = 5'd2;
        #1;
        check(rd_a_data === 32'h102, "R12", rd_a_data, 32'h102);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(rd_a_data === 32'h77, "R3", rd_a_data, 32'h77);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_globals();
        t_zero();
        t_windows();
        t_cycle();
        t_ovf();
        t_unf();
        t_both();
        t_rdw();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule